// File: doc/BRIEF.md
# Circular Self-Test Register Ring

This block is a register built from self-test flip-flop cells joined in one closed loop. Each cell has a functional data input from the logic around it, a serial input from the cell before it, and an output. In test operation every cell folds its functional input into the bit arriving from its neighbour. The whole register therefore produces patterns and compacts responses in the same clock cycle. The last cell feeds the first, so the loop has the characteristic polynomial 1+x^m, where m is the number of cells.

A 2-bit mode input selects one of four operations: functional capture, test compaction, synchronous clear and serial shift. In shift operation the loop is opened. The first cell takes a scan-in pin and the last cell drives a scan-out pin, so a seed can be loaded and a result unloaded. A build parameter selects a reduced cell control instead. In that variant only the low mode bit is used, and it chooses between functional capture and test compaction.

After a test session the register contents are the signature. A comparator checks them against an expected value and gives a pass indication.

Top module: `ring_bist_reg`

## Requirements
- R1: While rst_n is low, every cell is held at 0 and state_q reads zero.
- R2: With mode = 2'b00 (full control), each cell j loads func_in[j] at the clock edge.
- R3: With mode = 2'b01 (full control), cell j loads func_in[j] XOR state_q[j-1], and cell 0 loads func_in[0] XOR state_q[WIDTH-1].
- R4: With mode = 2'b10 (full control), every cell loads 0 at the clock edge, whatever func_in holds.
- R5: With mode = 2'b11 (full control), cell j loads state_q[j-1] and cell 0 loads scan_in. scan_out always equals state_q[WIDTH-1].
- R6: During shift operation func_in has no effect on the next register contents.
- R7: In test operation with func_in held at zero, the contents rotate by one place toward higher indices each cycle. They return to their starting value after exactly WIDTH cycles, which is the period of 1+x^m.
- R8: sig_ok is 1 exactly when state_q equals exp_sig, in the same cycle.
- R9: With SIMPLE_CTRL = 1, mode[1] is ignored. mode[0] = 0 gives the R2 behaviour and mode[0] = 1 gives the R3 behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operation select: 00 capture, 01 test, 10 clear, 11 shift |
| func_in | input | WIDTH | Functional inputs, one per cell, from the logic under test |
| scan_in | input | 1 | Serial input to cell 0 during shift |
| exp_sig | input | WIDTH | Expected signature for comparison |
| state_q | output | WIDTH | Register contents |
| scan_out | output | 1 | Serial output, last cell |
| sig_ok | output | 1 | State equals expected signature |

## Verification
The bench builds two copies of the block. One uses the default full control and WIDTH = 8. It covers all four operations, a complete scan load through the opened chain, and a full 8-cycle rotation of a single one around the loop. The second uses SIMPLE_CTRL = 1 and WIDTH = 5, and its mode[1] is driven at random. This shows that the reduced control ignores that bit, and the odd width places the wrap from the last cell to cell 0 at a different position.

// File: rtl/ring_bist_pkg.sv
package ring_bist_pkg;

    typedef enum logic [1:0] {
        RB_RUN   = 2'b00,
        RB_MIX   = 2'b01,
        RB_ZERO  = 2'b10,
        RB_SHIFT = 2'b11
    } rb_mode_e;

    typedef struct packed {
        logic take_func;
        logic take_ser;
        logic zero;
        logic close_ring;
    } rb_sel_t;

endpackage

// File: rtl/ring_bist_dec.sv
module ring_bist_dec
    import ring_bist_pkg::*;
#(
    parameter bit SIMPLE_CTRL = 1'b0
) (
    input  logic [1:0] mode_i,
    output rb_sel_t    sel_o
);

    generate
        if (SIMPLE_CTRL) begin : g_simple
            always_comb begin
                sel_o            = '0;
                sel_o.take_func  = 1'b1;
                sel_o.take_ser   = mode_i[0];
                sel_o.close_ring = mode_i[0];
            end
        end else begin : g_full
            rb_mode_e md;
            assign md = rb_mode_e'(mode_i);
            always_comb begin
                sel_o = '0;
                case (md)
                    RB_RUN: begin
                        sel_o.take_func = 1'b1;
                    end
                    RB_MIX: begin
                        sel_o.take_func  = 1'b1;
                        sel_o.take_ser   = 1'b1;
                        sel_o.close_ring = 1'b1;
                    end
                    RB_ZERO: begin
                        sel_o.zero = 1'b1;
                    end
                    RB_SHIFT: begin
                        sel_o.take_ser = 1'b1;
                    end
                    default: sel_o = '0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/ring_bist_cell.sv
module ring_bist_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic take_func_i,
    input  logic take_ser_i,
    input  logic zero_i,
    input  logic func_i,
    input  logic ser_i,
    output logic q_o
);

    logic q_d;
    logic q_q;

    always_comb begin
        q_d = 1'b0;
        if (!zero_i) begin
            q_d = (take_func_i & func_i) ^ (take_ser_i & ser_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

endmodule

// File: rtl/ring_bist_cmp.sv
module ring_bist_cmp #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] exp_i,
    output logic             match_o
);

    logic [WIDTH-1:0] diff;

    always_comb begin
        diff    = state_i ^ exp_i;
        match_o = ~|diff;
    end

endmodule

// File: rtl/ring_bist_reg.sv
module ring_bist_reg
    import ring_bist_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter bit SIMPLE_CTRL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] func_in,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] exp_sig,
    output logic [WIDTH-1:0] state_q,
    output logic             scan_out,
    output logic             sig_ok
);

    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] ser;
    } feed_t;

    rb_sel_t          sel;
    feed_t            feed_d;
    logic [WIDTH-1:0] cell_q;

    ring_bist_dec #(.SIMPLE_CTRL(SIMPLE_CTRL)) u_dec (
        .mode_i (mode),
        .sel_o  (sel)
    );

    always_comb begin
        feed_d.ser    = {cell_q[LAST-1:0], 1'b0};
        feed_d.ser[0] = sel.close_ring ? cell_q[LAST] : scan_in;
    end

    generate
        for (genvar j = 0; j < WIDTH; j++) begin : g_cell
            ring_bist_cell u_cell (
                .clk         (clk),
                .rst_n       (rst_n),
                .take_func_i (sel.take_func),
                .take_ser_i  (sel.take_ser),
                .zero_i      (sel.zero),
                .func_i      (func_in[j]),
                .ser_i       (feed_d.ser[j]),
                .q_o         (cell_q[j])
            );
        end
    endgenerate

    ring_bist_cmp #(.WIDTH(WIDTH)) u_cmp (
        .state_i (cell_q),
        .exp_i   (exp_sig),
        .match_o (sig_ok)
    );

    assign state_q  = cell_q;
    assign scan_out = cell_q[LAST];

endmodule

// File: rtl/ring_bist_reg_chk.sv
module ring_bist_reg_chk #(
    parameter int WIDTH       = 8,
    parameter bit SIMPLE_CTRL = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] func_in,
    input logic             scan_in,
    input logic [WIDTH-1:0] exp_sig,
    input logic [WIDTH-1:0] state_q,
    input logic             scan_out,
    input logic             sig_ok
);

    logic is_run, is_mix, is_zero, is_shift;
    always_comb begin
        if (SIMPLE_CTRL) begin
            is_run   = !mode[0];
            is_mix   = mode[0];
            is_zero  = 1'b0;
            is_shift = 1'b0;
        end else begin
            is_run   = (mode == 2'b00);
            is_mix   = (mode == 2'b01);
            is_zero  = (mode == 2'b10);
            is_shift = (mode == 2'b11);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (state_q == '0); // R1
        end
    end

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        is_run |=> state_q == $past(func_in)); // R2

    AST_MIX_RING: assert property (@(posedge clk) disable iff (!rst_n)
        is_mix |=> state_q == $past(func_in ^ {state_q[WIDTH-2:0], state_q[WIDTH-1]})); // R3

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        is_zero |=> state_q == '0); // R4

    AST_SHIFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        is_shift |=> state_q == $past({state_q[WIDTH-2:0], scan_in})); // R5

    AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        is_shift |=> scan_out == $past(state_q[WIDTH-2])); // R5

    AST_SIG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sig_ok == (state_q == exp_sig)); // R8

endmodule

bind ring_bist_reg ring_bist_reg_chk #(.WIDTH(WIDTH), .SIMPLE_CTRL(SIMPLE_CTRL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .func_in  (func_in),
    .scan_in  (scan_in),
    .exp_sig  (exp_sig),
    .state_q  (state_q),
    .scan_out (scan_out),
    .sig_ok   (sig_ok)
);

// File: tb/sim_ring_bist_reg.sv
module sim_ring_bist_reg;

    localparam int CLK_PERIOD = 10;
    localparam int WA = 8;
    localparam int WB = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_a, mode_b;
    logic [WA-1:0] fin_a, exp_a, st_a;
    logic [WB-1:0] fin_b, exp_b, st_b;
    logic          sin_a, sin_b, sout_a, sout_b, ok_a, ok_b;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] mdl_a = '0;
    logic [7:0] mdl_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_bist_reg #(.WIDTH(WA), .SIMPLE_CTRL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode_a), .func_in(fin_a), .scan_in(sin_a),
        .exp_sig(exp_a), .state_q(st_a), .scan_out(sout_a), .sig_ok(ok_a));

    ring_bist_reg #(.WIDTH(WB), .SIMPLE_CTRL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .mode(mode_b), .func_in(fin_b), .scan_in(sin_b),
        .exp_sig(exp_b), .state_q(st_b), .scan_out(sout_b), .sig_ok(ok_b));

    // Reference next state computed from the requirements (R2..R5, R9)
    function automatic logic [7:0] ref_next(input int w, input bit simple, input logic [1:0] md,
                                            input logic [7:0] q, input logic [7:0] d, input logic sin);
        logic [7:0] r;
        logic [1:0] eff;
        r = '0;
        eff = simple ? (md[0] ? 2'b01 : 2'b00) : md;
        for (int j = 0; j < w; j++) begin
            logic prev;
            if (j == 0) prev = (eff == 2'b01) ? q[w-1] : sin;
            else        prev = q[j-1];
            case (eff)
                2'b00: r[j] = d[j];
                2'b01: r[j] = d[j] ^ prev;
                2'b10: r[j] = 1'b0;
                default: r[j] = prev;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Called at a negedge; applies one vector to both copies and checks after the edge
    task automatic step(input logic [1:0] ma, input logic [7:0] da, input logic sa, input bit hit_a,
                        input logic [1:0] mb, input logic [7:0] db, input logic sb, input bit hit_b);
        logic [7:0] na, nb;
        na = ref_next(WA, 1'b0, ma, mdl_a, da, sa);
        nb = ref_next(WB, 1'b1, mb, mdl_b, db, sb) & 8'h1f;
        mode_a = ma; fin_a = da; sin_a = sa;
        mode_b = mb; fin_b = db[WB-1:0]; sin_b = sb;
        exp_a = hit_a ? na : na ^ 8'h80;
        exp_b = hit_b ? nb[WB-1:0] : nb[WB-1:0] ^ 5'h01;
        @(posedge clk);
        @(negedge clk);
        mdl_a = na;
        mdl_b = nb;
        check(ma == 2'b00 ? "R2" : ma == 2'b01 ? "R3" : ma == 2'b10 ? "R4" : "R5/R6", st_a, na);
        check("R9", {3'b0, st_b}, nb);
        check("R5 scan_out", {7'b0, sout_a}, {7'b0, na[WA-1]});
        check("R8 a", {7'b0, ok_a}, {7'b0, hit_a});
        check("R8 b", {7'b0, ok_b}, {7'b0, hit_b});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] start;
        void'($urandom(32'h1c0ffee5));
        rst_n = 1'b0;
        mode_a = 2'b00; fin_a = 8'hff; sin_a = 1'b1; exp_a = '0;
        mode_b = 2'b00; fin_b = 5'h1f; sin_b = 1'b1; exp_b = '0;
        repeat (3) @(negedge clk);
        check("R1 a", st_a, 8'h00);
        check("R1 b", {3'b0, st_b}, 8'h00);
        rst_n = 1'b1;

        // R2 capture of several patterns
        step(2'b00, 8'ha5, 0, 1, 2'b10, 8'h15, 0, 1);
        step(2'b00, 8'h3c, 1, 0, 2'b00, 8'h0a, 1, 1);
        // R3 test compaction with wrap from last cell
        step(2'b01, 8'h81, 0, 1, 2'b11, 8'h11, 0, 0);
        // R4 clear with non-zero func_in
        step(2'b10, 8'hff, 1, 1, 2'b01, 8'h1f, 1, 1);
        // R5/R6 scan load of 8'b1011_0010 while func_in is random
        for (int k = 7; k >= 0; k--) begin
            step(2'b11, 8'($urandom), logic'((8'hb2 >> k) & 1), 1, 2'b00, 8'($urandom), 0, 1);
        end
        check("R5 loaded seed", st_a, 8'hb2);
        // R7 single one around the loop, func_in zero
        step(2'b10, 8'h00, 0, 1, 2'b00, 8'h01, 0, 1);
        step(2'b00, 8'h01, 0, 1, 2'b00, 8'h01, 0, 1);
        start = st_a;
        for (int k = 0; k < WA; k++) begin
            step(2'b01, 8'h00, 0, 1, 2'b01, 8'h00, 0, 1);
            if (k < WA - 1) check("R7 rotate", st_a, 8'(start << (k + 1)));
        end
        check("R7 period", st_a, start);
        check("R7 period b", {3'b0, st_b}, 8'h08);

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] ma;
            logic [7:0] da;
            ma = 2'($urandom);
            da = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            step(ma, da, 1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule